// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver

This block sits beside a small 8-bit microcontroller core. It collects thirteen primary interrupt requests and keeps a pending flag for each one. It then picks the highest-ranked request that is enabled and presents that request's vector address to the core. Each request is gated by its own enable bit and by a global enable. When the core acknowledges, the pending flag of the granted source is cleared.

One primary source is the USB vector at 0x43, and it is shared. Behind it, a second-level stage holds twenty-two USB sub-event flags, each with its own enable. When the USB vector is acknowledged, this stage picks the lowest-numbered enabled pending sub-event. It latches that sub-event's jump-table offset, so interrupt code can branch through a table with 4-byte entries.

Top module: `irq_vector_resolver`

## Requirements
- R1: After reset, `irq_valid` is 0, `irq_vector` is 0x00, `usb_offset` is 0x00 and no request is pending.
- R2: Source index i (bit i of `irq_in`) has the vector 8*i+3. The sources are:
  - 0 ext int0 (0x03)
  - 1 timer0 (0x0B)
  - 2 ext int1 (0x13)
  - 3 timer1 (0x1B)
  - 4 UART0 (0x23)
  - 5 timer2 (0x2B)
  - 6 wakeup (0x33)
  - 7 UART1 (0x3B)
  - 8 USB (0x43)
  - 9 I2C (0x4B)
  - 10 FIFO/int4 (0x53)
  - 11 int5 (0x5B)
  - 12 int6 (0x63)
- R3: A pending source is a candidate only when its `src_en` bit and `glob_en` are both 1. While either is 0, the source stays pending without being granted, and `src_en` bit 12 gates int6.
- R4: Among the candidates, wakeup (index 6) wins. After it, a lower index beats a higher one. The result is resolved in the same cycle.
- R5: A rising edge on `irq_in` bit i sets pending i at the next clock edge. A level held high does not set pending i again after it has been cleared.
- R6: `ack` while `irq_valid` is 1 clears only the granted source's pending flag. A new rising edge on that source in the same cycle leaves it pending. `ack` while `irq_valid` is 0 has no effect.
- R7: The USB vector 0x43 is requested when pending bit 8 is set or any USB sub-event is both pending and enabled.
- R8: The selected USB sub-event is the lowest-indexed one that is pending and enabled. Its offset is 4*index, in the range 0x00 to 0x54.
- R9: `usb_offset` changes only on an `ack` that grants the USB vector while a sub-event is selected. That ack also clears the sub-event's pending flag. At all other times `usb_offset` holds its value.
- R10: Sub-event index map:
  - 0 setup data available
  - 1 start of frame
  - 2 setup token
  - 3 suspend
  - 4 bus reset
  - 5 IN bulk NAK
  - 6 and 7 are endpoint 0 IN and OUT
  - 8+2(n-1) and 9+2(n-1) are endpoint n IN and OUT, for n from 1 to 7

  A rising edge on `usb_req` bit s sets sub-pending s. A `usb_en` value of 0x1F enables indices 0 to 4 and leaves index 5 disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 13 | Primary request lines, edge-detected |
| src_en | input | 13 | Per-source enables |
| glob_en | input | 1 | Global enable |
| usb_req | input | 22 | USB sub-event request lines, edge-detected |
| usb_en | input | 22 | USB sub-event enables |
| ack | input | 1 | Core acknowledge of the presented vector |
| irq_valid | output | 1 | A candidate is present |
| irq_vector | output | 8 | Vector address of the winner, 0 when none |
| usb_offset | output | 8 | Latched USB jump-table offset |

## Verification
A pending flag that is wrong shows up one cycle after the edge that set or cleared it. It appears at the ports either as a vector that is missing or as an extra vector, and a sequence of acks exposes it by giving the wrong order of vectors. A wrong priority rank is visible at once, because the vector is combinational from the pending flags. A sub-event flag or selection that is wrong stays hidden until the USB vector is acknowledged. At that ack, `usb_offset` takes a wrong value, or the USB request persists or vanishes early.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int NSRC     = 13;
  localparam int NSUB     = 22;
  localparam int WAKE_SRC = 6;
  localparam int USB_SRC  = 8;

  function automatic logic [7:0] prim_vector(input logic [3:0] idx);
    return {1'b0, idx, 3'b011};
  endfunction

  function automatic int rank_src(input int k, input int wake);
    if (k == 0) return wake;
    else if (k <= wake) return k - 1;
    else return k;
  endfunction

  function automatic logic [7:0] sub_offset(input logic [4:0] s);
    return {1'b0, s, 2'b00};
  endfunction
endpackage

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_in,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend,
  output logic [W-1:0] set_ev
);
  logic [W-1:0] prev;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign set_ev[i] = req_in[i] & ~prev[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev[i] <= 1'b0;
        pend[i] <= 1'b0;
      end else begin
        prev[i] <= req_in[i];
        pend[i] <= set_ev[i] | (pend[i] & ~clr[i]);
      end
    end

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      set_ev[i] |=> pend[i]); // R6
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      clr[i] && !set_ev[i] |=> !pend[i]); // R6
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_res_pkg::*;
#(
  parameter int W    = NSRC,
  parameter int WAKE = WAKE_SRC,
  localparam int IW  = $clog2(W)
) (
  input  logic [W-1:0]  cand,
  output logic          valid,
  output logic [IW-1:0] win,
  output logic [W-1:0]  grant
);
  always_comb begin
    win   = '0;
    grant = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (cand[rank_src(k, WAKE)]) begin
        win   = IW'(rank_src(k, WAKE));
        grant = '0;
        grant[rank_src(k, WAKE)] = 1'b1;
      end
    end
    valid = |cand;
  end
endmodule

// File: rtl/usb_autovec.sv
module usb_autovec
  import irq_res_pkg::*;
#(
  parameter int N   = NSUB,
  localparam int SW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sub_pend,
  input  logic [N-1:0] sub_en,
  input  logic         take,
  output logic         sub_any,
  output logic [N-1:0] sub_clr,
  output logic [7:0]   offset
);
  logic [N-1:0]  live;
  logic [SW-1:0] sel;
  logic          latch_now;

  assign live    = sub_pend & sub_en;
  assign sub_any = |live;

  always_comb begin
    sel = '0;
    for (int s = N - 1; s >= 0; s--)
      if (live[s]) sel = SW'(s);
  end

  assign latch_now = take & sub_any;

  always_comb begin
    sub_clr = '0;
    if (latch_now) sub_clr[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) offset <= 8'h00;
    else if (latch_now) offset <= sub_offset(5'(sel));
  end

  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_now |=> $stable(offset)); // R9
  AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    offset[1:0] == 2'b00 && offset <= 8'h54); // R8
endmodule

// File: rtl/irq_vector_resolver.sv
module irq_vector_resolver
  import irq_res_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic [NSRC-1:0] src_en,
  input  logic            glob_en,
  input  logic [NSUB-1:0] usb_req,
  input  logic [NSUB-1:0] usb_en,
  input  logic            ack,
  output logic            irq_valid,
  output logic [7:0]      irq_vector,
  output logic [7:0]      usb_offset
);
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] pend, set_ev, req_vec, cand, grant, clr;
  logic [NSUB-1:0] sub_pend, sub_set, sub_clr;
  logic [IW-1:0]   win;
  logic            sub_any, take, usb_take;

  irq_edge_pend #(.W(NSRC)) u_prim_pend (
    .clk(clk), .rst_n(rst_n), .req_in(irq_in), .clr(clr),
    .pend(pend), .set_ev(set_ev));

  irq_edge_pend #(.W(NSUB)) u_sub_pend (
    .clk(clk), .rst_n(rst_n), .req_in(usb_req), .clr(sub_clr),
    .pend(sub_pend), .set_ev(sub_set));

  always_comb begin
    req_vec          = pend;
    req_vec[USB_SRC] = pend[USB_SRC] | sub_any;
  end

  assign cand = req_vec & src_en & {NSRC{glob_en}};

  irq_prio_pick #(.W(NSRC), .WAKE(WAKE_SRC)) u_pick (
    .cand(cand), .valid(irq_valid), .win(win), .grant(grant));

  assign take     = ack & irq_valid;
  assign clr      = take ? grant : '0;
  assign usb_take = take & grant[USB_SRC];

  usb_autovec #(.N(NSUB)) u_usb (
    .clk(clk), .rst_n(rst_n), .sub_pend(sub_pend), .sub_en(usb_en),
    .take(usb_take), .sub_any(sub_any), .sub_clr(sub_clr),
    .offset(usb_offset));

  assign irq_vector = irq_valid ? prim_vector(4'(win)) : 8'h00;

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_en |-> !irq_valid); // R3
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> src_en[win] && req_vec[win]); // R3
  AST_GRANT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (irq_valid == (grant != '0))); // R4
  AST_WAKE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cand[WAKE_SRC] |-> irq_vector == 8'h33); // R4
  AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !irq_valid && sub_set == '0 |=> $stable(sub_pend)); // R6
endmodule

// File: tb/tb_irq_vector_resolver.sv
module tb_irq_vector_resolver;
  logic        clk = 0, rst_n = 0, glob_en = 0, ack = 0;
  logic [12:0] irq_in = '0, src_en = '0;
  logic [21:0] usb_req = '0, usb_en = '0;
  logic        irq_valid;
  logic [7:0]  irq_vector, usb_offset;
  int total = 0, bad = 0;

  irq_vector_resolver dut (.*);

  always #2 clk = ~clk;

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int vec_of(int i); return i * 8 + 3; endfunction

  task automatic do_ack();
    ack = 1; step(); ack = 0;
  endtask

  task automatic t_reset();
    chk("R1 valid", irq_valid, 0);
    chk("R1 vector", irq_vector, 0);
    chk("R1 offset", usb_offset, 0);
  endtask

  task automatic t_each_vector();
    for (int i = 0; i < 13; i++) begin
      irq_in[i] = 1; step();
      chk("R2 vector", irq_vector, vec_of(i));
      chk("R5 valid after edge", irq_valid, 1);
      do_ack();
      chk("R5 held level no retrigger", irq_valid, 0);
      irq_in[i] = 0; step();
    end
  endtask

  task automatic t_priority();
    int order [13] = '{6, 0, 1, 2, 3, 4, 5, 7, 8, 9, 10, 11, 12};
    irq_in = '1; step(); irq_in = '0;
    for (int k = 0; k < 13; k++) begin
      chk("R4 rank order", irq_vector, vec_of(order[k]));
      do_ack();
    end
    chk("R4 all served", irq_valid, 0);
  endtask

  task automatic t_gating();
    glob_en = 0; irq_in[3] = 1; step(); irq_in[3] = 0;
    chk("R3 global off", irq_valid, 0);
    do_ack();
    glob_en = 1; #1;
    chk("R6 idle ack ignored, R3 pending kept", irq_vector, 8'h1B);
    src_en[3] = 0; #1;
    chk("R3 source disabled", irq_valid, 0);
    src_en[3] = 1; do_ack();
    chk("R6 cleared", irq_valid, 0);
    src_en[12] = 0; irq_in[12] = 1; step(); irq_in[12] = 0;
    chk("R3 int6 gated by bit 12", irq_valid, 0);
    src_en[12] = 1; #1;
    chk("R3 int6 enabled", irq_vector, 8'h63);
    do_ack();
  endtask

  task automatic t_same_cycle_edge();
    irq_in[2] = 1; step(); irq_in[2] = 0; step();
    irq_in[0] = 1; step();
    chk("R4 int0 over int1", irq_vector, 8'h03);
    do_ack(); irq_in[0] = 0;
    chk("R6 only granted cleared", irq_vector, 8'h13);
    ack = 1; irq_in[2] = 1; step(); ack = 0;
    chk("R6 new edge survives ack", irq_vector, 8'h13);
    do_ack(); irq_in[2] = 0;
    chk("R6 cleared after second ack", irq_valid, 0);
  endtask

  task automatic t_usb();
    usb_en = 22'h1F;
    usb_req[5] = 1; step(); usb_req[5] = 0;
    chk("R10 IN-NAK disabled by 0x1F", irq_valid, 0);
    usb_en = '1; #1;
    chk("R7 USB vector", irq_vector, 8'h43);
    usb_req[3] = 1; usb_req[20] = 1; step(); usb_req = '0;
    do_ack(); chk("R8 lowest first", usb_offset, 8'h0C);
    chk("R7 still requested", irq_vector, 8'h43);
    do_ack(); chk("R8 next", usb_offset, 8'h14);
    do_ack(); chk("R8 EP7 IN", usb_offset, 8'h50);
    chk("R9 sub cleared", irq_valid, 0);
    usb_req[21] = 1; step(); usb_req = '0;
    do_ack(); chk("R8 last entry", usb_offset, 8'h54);
    irq_in[0] = 1; step(); irq_in[0] = 0;
    do_ack(); chk("R9 held on other ack", usb_offset, 8'h54);
    do_ack(); chk("R9 held on idle ack", usb_offset, 8'h54);
    usb_req[0] = 1; step(); usb_req = '0;
    glob_en = 0; do_ack(); glob_en = 1;
    chk("R9 held when not granted", usb_offset, 8'h54);
    do_ack(); chk("R8 setup data", usb_offset, 8'h00);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1; glob_en = 1; src_en = '1; step();
    t_each_vector();
    t_priority();
    t_gating();
    t_same_cycle_edge();
    t_usb();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule